// File: doc/BRIEF.md
# Dual-Mode Cascadable Column Data Loader

This block gathers serial display data for one row of column drivers. It works from a bank of `COLS` column bits, 80 by default. All of its activity is timed by falling edges of a slow shift clock, which is sampled in the system clock domain. The block has two modes, picked by `modeLatch`.

When `modeLatch` is low, the bank acts as a plain bidirectional shift register. Data arrives on one I/O pin and leaves on the opposite one, which lets several loaders be chained into one long register. When `modeLatch` is high, the block is a nibble-addressed latch array. Serial bits are grouped four at a time. A counter-driven selector writes each complete nibble into the next of `COLS/4` four-bit groups. Once the last group is written the selector stops, and an active-low carry enables the next loader in a chain. A falling edge of the line clock rearms the counters and releases the carry for the next row.

Top module: `colLoader`

## Requirements
- R1: After reset, `columns` is all zero and `carryN` is high.
- R2: With `modeLatch`=0 and `dirRight`=0, every shift-clock fall moves each column up by one index and loads `ioLIn` into column 1 (`columns[0]`). After `COLS` falls, the first bit sits in column `COLS`. `ioROut` shows column `COLS` with `ioROe`=1 and `ioLOe`=0.
- R3: With `modeLatch`=0 and `dirRight`=1, every fall moves each column down by one index and loads `ioRIn` into column `COLS`. After `COLS` falls, the first bit sits in column 1. `ioLOut` shows column 1 with `ioLOe`=1 and `ioROe`=0.
- R4: In shift mode, `enableN` has no effect on shifting, and `carryN` stays high.
- R5: In latch mode, while `enableN` is high, shift-clock falls leave `columns` unchanged.
- R6: In latch mode with `dirRight`=0, data is taken from `dataL`. The k-th bit since rearm lands in column k. A group of four columns changes only on the fall that delivers the fourth bit of its nibble.
- R7: In latch mode with `dirRight`=1, data is taken from `dataR`, and the k-th bit since rearm lands in column `COLS`+1-k. Nibble-wise writing applies as in R6.
- R8: `carryN` goes low on the same clock edge that writes the final nibble and stays low until rearm. After that, further falls leave `columns` unchanged whatever the data.
- R9: A falling edge of `lineClk` raises `carryN` and resets the bit and nibble counters, so the next bit counts as bit 1. Columns are not altered by it.
- R10: Only a falling edge of `shiftClk` acts. A rising edge, or a level held for many cycles, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLatch | input | 1 | 0 = shift-register mode, 1 = nibble-latch mode |
| enableN | input | 1 | Active-low load enable (latch mode only) |
| dirRight | input | 1 | Direction select (0 = data from the left side) |
| shiftClk | input | 1 | Serial shift clock, acts on its falling edge |
| lineClk | input | 1 | Line clock, its falling edge rearms the loader |
| dataL | input | 1 | Left serial input in latch mode |
| dataR | input | 1 | Right serial input in latch mode |
| ioLIn | input | 1 | Left I/O pin, input side |
| ioRIn | input | 1 | Right I/O pin, input side |
| ioLOut | output | 1 | Left I/O pin, driven value (column 1) |
| ioLOe | output | 1 | Left I/O pin drive enable |
| ioROut | output | 1 | Right I/O pin, driven value (column `COLS`) |
| ioROe | output | 1 | Right I/O pin drive enable |
| carryN | output | 1 | Active-low chip-enable carry to the next loader |
| columns | output | COLS | Column data, bit i = column i+1 |

## Verification
A fall on `shiftClk` or `lineClk` is found on the first `clk` edge that sees the pin low after seeing it high. `columns` and `carryN` change on that same edge, so both follow the pin fall by one clock edge. The bench changes the pins on falling `clk` edges and holds each pin level for one full cycle. It then samples two falling edges after raising the shift clock, which is one cycle after the acting edge. A bench model, updated per pulse from the requirements, supplies the expected columns and carry for that sample.

// File: rtl/colLoaderPkg.sv
package colLoaderPkg;

  // Strobes issued by the control unit to the datapath each clock.
  typedef struct packed {
    logic shiftUp;    // shift mode, move toward higher columns
    logic shiftDown;  // shift mode, move toward lower columns
    logic takeBit;    // latch mode, accept one serial bit
    logic writeNib;   // latch mode, commit assembled nibble
    logic dirHigh;    // latch mode, mirrored placement
  } ldrStrobe_t;

endpackage

// File: rtl/colLoaderCtrl.sv
module colLoaderCtrl
  import colLoaderPkg::*;
#(
  parameter int SLOTS = 20,
  parameter int IDXW  = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeLatch,
  input  logic            enableN,
  input  logic            dirRight,
  input  logic            shiftClk,
  input  logic            lineClk,
  output ldrStrobe_t      strobe,
  output logic [IDXW-1:0] slotIdx,
  output logic            carryN
);

  localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(SLOTS - 1);

  logic       sClkQ, lClkQ;
  logic       shiftFall, lineFall;
  logic [1:0] bitCnt;
  logic [IDXW-1:0] nibIdx;
  logic       doneQ, carryQ;
  logic       loadNow, nibbleEnd;

  // edge detection of the slow clocks in the system domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sClkQ <= 1'b0;
      lClkQ <= 1'b0;
    end else begin
      sClkQ <= shiftClk;
      lClkQ <= lineClk;
    end
  end

  assign shiftFall = sClkQ & ~shiftClk;
  assign lineFall  = lClkQ & ~lineClk;

  assign loadNow   = modeLatch & ~enableN & ~doneQ & shiftFall & ~lineFall;
  assign nibbleEnd = (bitCnt == 2'd3);

  // bit counter, nibble selector and carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      nibIdx <= '0;
      doneQ  <= 1'b0;
      carryQ <= 1'b1;
    end else if (lineFall) begin
      bitCnt <= '0;
      nibIdx <= '0;
      doneQ  <= 1'b0;
      carryQ <= 1'b1;
    end else if (loadNow) begin
      bitCnt <= bitCnt + 2'd1;
      if (nibbleEnd) begin
        if (nibIdx == LAST_SLOT) begin
          doneQ  <= 1'b1;
          carryQ <= 1'b0;
        end else begin
          nibIdx <= nibIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.shiftUp   = ~modeLatch & shiftFall & ~dirRight;
    strobe.shiftDown = ~modeLatch & shiftFall & dirRight;
    strobe.takeBit   = loadNow;
    strobe.writeNib  = loadNow & nibbleEnd;
    strobe.dirHigh   = dirRight;
  end

  assign slotIdx = nibIdx;
  assign carryN  = modeLatch ? carryQ : 1'b1;

endmodule

// File: rtl/colLoaderPath.sv
module colLoaderPath
  import colLoaderPkg::*;
#(
  parameter int COLS  = 80,
  parameter int SLOTS = COLS / 4,
  parameter int IDXW  = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ldrStrobe_t      strobe,
  input  logic [IDXW-1:0] slotIdx,
  input  logic            serBit,
  input  logic            ioLIn,
  input  logic            ioRIn,
  output logic [COLS-1:0] columns
);

  logic [2:0]             acc;
  logic [3:0]             fullNib, revNib, placeNib;
  logic [SLOTS-1:0][3:0]  grpNext;
  logic [COLS-1:0]        colReg;

  // serial-to-parallel: acc[0] holds the earliest bit of the nibble
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strobe.takeBit) acc <= {serBit, acc[2:1]};
  end

  assign fullNib  = {serBit, acc};
  assign revNib   = {fullNib[0], fullNib[1], fullNib[2], fullNib[3]};
  assign placeNib = strobe.dirHigh ? revNib : fullNib;

  // selector: one decoder per physical group, mirrored for high direction
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = strobe.writeNib &&
                 (strobe.dirHigh ? (slotIdx == IDXW'(SLOTS - 1 - g))
                                 : (slotIdx == IDXW'(g)));
    assign grpNext[g] = hit ? placeNib : colReg[4*g +: 4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  colReg <= '0;
    else if (strobe.shiftUp)    colReg <= {colReg[COLS-2:0], ioLIn};
    else if (strobe.shiftDown)  colReg <= {ioRIn, colReg[COLS-1:1]};
    else if (strobe.writeNib)   colReg <= grpNext;
  end

  assign columns = colReg;

endmodule

// File: rtl/colLoader.sv
module colLoader
  import colLoaderPkg::*;
#(
  parameter int COLS = 80
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeLatch,
  input  logic            enableN,
  input  logic            dirRight,
  input  logic            shiftClk,
  input  logic            lineClk,
  input  logic            dataL,
  input  logic            dataR,
  input  logic            ioLIn,
  input  logic            ioRIn,
  output logic            ioLOut,
  output logic            ioLOe,
  output logic            ioROut,
  output logic            ioROe,
  output logic            carryN,
  output logic [COLS-1:0] columns
);

  localparam int SLOTS = COLS / 4;
  localparam int IDXW  = $clog2(SLOTS);

  ldrStrobe_t      strobe;
  logic [IDXW-1:0] slotIdx;
  logic            serBit;

  assign serBit = dirRight ? dataR : dataL;

  colLoaderCtrl #(.SLOTS(SLOTS), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeLatch(modeLatch), .enableN(enableN),
    .dirRight(dirRight), .shiftClk(shiftClk), .lineClk(lineClk),
    .strobe(strobe), .slotIdx(slotIdx), .carryN(carryN)
  );

  colLoaderPath #(.COLS(COLS), .SLOTS(SLOTS), .IDXW(IDXW)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .serBit(serBit), .ioLIn(ioLIn), .ioRIn(ioRIn), .columns(columns)
  );

  // the pin on the far side of the data flow drives the last stage
  assign ioROut = columns[COLS-1];
  assign ioROe  = ~modeLatch & ~dirRight;
  assign ioLOut = columns[0];
  assign ioLOe  = ~modeLatch & dirRight;

endmodule

// File: rtl/colLoaderChk.sv
module colLoaderChk #(
  parameter int COLS = 80
) (
  input logic            clk,
  input logic            rstN,
  input logic            modeLatch,
  input logic            enableN,
  input logic            dirRight,
  input logic            shiftClk,
  input logic            lineClk,
  input logic            dataL,
  input logic            dataR,
  input logic            ioLIn,
  input logic            ioRIn,
  input logic            ioLOut,
  input logic            ioLOe,
  input logic            ioROut,
  input logic            ioROe,
  input logic            carryN,
  input logic [COLS-1:0] columns
);

  logic sQ, lQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sQ <= 1'b0;
      lQ <= 1'b0;
    end else begin
      sQ <= shiftClk;
      lQ <= lineClk;
    end
  end

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(sQ && !shiftClk) |=> $stable(columns));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatch && enableN) |=> $stable(columns));

  p_done_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatch && !carryN) |=> $stable(columns));

  p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeLatch && !carryN && !(lQ && !lineClk)) |=> (!carryN || !modeLatch));

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lQ && !lineClk) |=> carryN);

  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ioLOe, ioROe}));

endmodule

bind colLoader colLoaderChk #(.COLS(COLS)) u_chk (.*);

// File: tb/colLoader_bench.sv
`timescale 1ns/1ps
module colLoader_bench;

  localparam int N = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeLatch = 1'b0, enableN = 1'b1, dirRight = 1'b0;
  logic shiftClk = 1'b0, lineClk = 1'b0;
  logic dataL = 1'b0, dataR = 1'b0, ioLIn = 1'b0, ioRIn = 1'b0;
  logic ioLOut, ioLOe, ioROut, ioROe, carryN;
  logic [N-1:0] columns;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] expCols = '0;
  logic [3:0]   pend = '0;
  int           mcnt = 0;

  always #10 clk = ~clk;

  colLoader #(.COLS(N)) u_colLoader (.*);

  task automatic checkVec(input string req, input logic [N-1:0] act, input logic [N-1:0] want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, want);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, want);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic dl, input logic dr, input logic il, input logic ir);
    @(negedge clk);
    dataL = dl; dataR = dr; ioLIn = il; ioRIn = ir;
    shiftClk = 1'b1;
    @(negedge clk);
    shiftClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic linePulse();
    @(negedge clk); lineClk = 1'b1;
    @(negedge clk); lineClk = 1'b0;
    @(negedge clk);
    mcnt = 0;
  endtask

  // latch-mode pulse with bench model update (R6, R7, R8)
  task automatic latchPulse(input logic b, input string req);
    logic n0, n1, n2;
    n0 = 1'($urandom); n1 = 1'($urandom); n2 = 1'($urandom);
    if (dirRight) pulse(n0, b, n1, n2);
    else          pulse(b, n0, n1, n2);
    if (!enableN && mcnt < N) begin
      pend[mcnt % 4] = b;
      if (mcnt % 4 == 3) begin
        for (int j = 0; j < 4; j++) begin
          if (dirRight) expCols[N-1-(mcnt-3+j)] = pend[j];
          else          expCols[mcnt-3+j] = pend[j];
        end
      end
      mcnt++;
    end
    checkVec(req, columns, expCols);
    checkBit("R8 carry", carryN, (mcnt >= N) ? 1'b0 : 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic b;
    void'($urandom(32'h5EED_0042));
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkVec("R1 reset columns", columns, '0);
    checkBit("R1 reset carry", carryN, 1'b1);

    // R2: shift toward column N, enable toggled randomly (R4)
    modeLatch = 1'b0; dirRight = 1'b0;
    for (int i = 0; i < N; i++) begin
      b = 1'($urandom);
      enableN = 1'($urandom);
      pulse(1'($urandom), 1'($urandom), b, ~b);
      expCols = {expCols[N-2:0], b};
      if (i % 16 == 15) checkVec("R2 shift up", columns, expCols);
      if (i % 20 == 0) checkBit("R4 carry idle", carryN, 1'b1);
    end
    checkBit("R2 right out", ioROut, expCols[N-1]);
    checkBit("R2 right oe", ioROe, 1'b1);
    checkBit("R2 left oe", ioLOe, 1'b0);

    // R3: mirrored direction
    dirRight = 1'b1;
    for (int i = 0; i < N; i++) begin
      b = (i == 0) ? 1'b1 : 1'($urandom);
      enableN = 1'($urandom);
      pulse(1'($urandom), 1'($urandom), ~b, b);
      expCols = {b, expCols[N-1:1]};
      if (i % 16 == 15) checkVec("R3 shift down", columns, expCols);
    end
    checkBit("R3 first bit at column 1", columns[0], 1'b1);
    checkBit("R3 left out", ioLOut, expCols[0]);
    checkBit("R3 left oe", ioLOe, 1'b1);
    checkBit("R4 carry shift", carryN, 1'b1);

    // R10: rising edge and held levels do nothing, the fall acts
    @(negedge clk); ioRIn = ~expCols[N-1]; shiftClk = 1'b1;
    repeat (5) tick();
    checkVec("R10 rise no effect", columns, expCols);
    shiftClk = 1'b0;
    tick();
    expCols = {ioRIn, expCols[N-1:1]};
    checkVec("R10 fall acts", columns, expCols);
    repeat (5) tick();
    checkVec("R10 low level no effect", columns, expCols);

    // latch mode
    modeLatch = 1'b1; dirRight = 1'b0;
    linePulse();
    checkBit("R9 carry after rearm", carryN, 1'b1);
    enableN = 1'b1;
    for (int i = 0; i < 6; i++) latchPulse(1'($urandom), "R5 disabled");

    // R6: full left-entry load, random data with a directed first nibble
    enableN = 1'b0;
    for (int i = 0; i < N; i++) begin
      b = (i < 4) ? ((i == 0) ? 1'b1 : 1'b0) : 1'($urandom);
      latchPulse(b, "R6 left load");
    end
    checkBit("R6 column 1 holds bit 1", columns[0], 1'b1);
    for (int i = 0; i < 8; i++) latchPulse(1'($urandom), "R8 frozen");

    linePulse();
    checkBit("R9 carry released", carryN, 1'b1);
    checkVec("R9 columns kept", columns, expCols);

    // R7: right-entry load
    dirRight = 1'b1;
    for (int i = 0; i < N; i++) begin
      b = (i == 0) ? ~columns[N-1] : 1'($urandom);
      latchPulse(b, "R7 right load");
    end
    for (int i = 0; i < 4; i++) latchPulse(1'($urandom), "R8 frozen right");

    // R9: partial load, rearm, next nibble returns to the first group
    linePulse();
    for (int i = 0; i < 6; i++) latchPulse(1'($urandom), "R9 partial");
    linePulse();
    for (int i = 0; i < 4; i++) latchPulse(1'($urandom), "R9 restart group");

    // R5 again after rearm with enable high
    enableN = 1'b1;
    for (int i = 0; i < 4; i++) latchPulse(1'($urandom), "R5 gated after rearm");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule